// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It walks a four-level hierarchy of in-memory tables. Each table holds 512 entries of 64 bits. The walk starts from a root table frame number. At each level a 9-bit slice of the virtual address selects the entry to read. An entry either points to the next table or, at the two middle levels, maps a large page directly.

A requester offers one translation at a time through a valid/ready handshake. The request carries the access kind: read or write, user or supervisor, and data or instruction fetch. The walker then issues entry reads one at a time on a request/valid memory port. It returns one of two results. On success it returns the physical address and a page-size code. Otherwise it returns a fault with a 16-bit error code. The result stays on the outputs until the requester takes it. When the paging-enable input is low, the walker passes the address through unchanged.

Top module: `pgwalk_top`

## Requirements
- R1: Each entry read goes to address (frame << 12) + index * 8, truncated to PA_W bits. For the first read the frame is `root_frame`. For later reads it is bits 51:12 of the previous entry. The index is taken from virtual address bits 47:39, 38:30, 29:21 and 20:12 at the first, second, third and fourth read.
- R2: When paging is enabled, an address whose bits 63:47 are not all equal faults without any entry read. Its error code has bit 0 clear.
- R3: A present second-level entry with bit 7 set ends the walk with a 1GB page. The result is {entry[51:30], va[29:0]} and the size code is 2.
- R4: A present third-level entry with bit 7 set ends the walk with a 2MB page. The result is {entry[51:21], va[20:0]} and the size code is 1.
- R5: Otherwise the fourth-level entry maps a 4KB page. Its bit 7 does not end anything early. The result is {entry[51:12], va[11:0]} and the size code is 0. Result bits 63:52 are zero for every translated address.
- R6: An entry with bit 0 (present) clear faults at once. Its error code has bits 0 and 3 clear.
- R7: Some bits of a present entry are reserved, and a set reserved bit faults with error code bits 0 and 3 set. In every entry, bits 51:PA_W are reserved. In a 2MB entry, bits 20:13 are also reserved. In a 1GB entry, bits 29:13 are also reserved. Bit 12 of a large-page entry is neither reserved nor part of the address.
- R8: Permissions are checked only at the final entry, using all entries visited. A write faults if any entry has bit 1 clear. A user access faults if any entry has bit 2 clear. A fetch faults if any entry has bit 63 set. Such a fault sets error code bit 0. The not-present check takes priority over the reserved-bit check, which takes priority over the permission checks.
- R9: In the error code, bit 1 marks a write, bit 2 a user access and bit 4 a fetch. Bits 15:5 are always zero. On success the whole code is zero.
- R10: With `paging_en` low at acceptance, the result appears in the cycle right after acceptance. It carries `rsp_pa` equal to the full 64-bit `req_va` and no fault, and no entry is read.
- R11: `mem_req_valid` is a one-cycle pulse. No new read is issued until `mem_rsp_valid` has returned data for the previous one.
- R12: `req_ready` is high only while no walk or result is pending, so it is never high together with `rsp_valid`. The result outputs hold steady until a cycle with `rsp_ready` high, and the walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Translation enable, sampled at acceptance |
| root_frame | input | 40 | Frame number (address bits 51:12) of the top table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Result is a fault |
| rsp_pa | output | 64 | Physical address |
| rsp_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| rsp_err | output | 16 | Fault error code |

## Verification
The hardest outcomes to reach are those that depend on how checks combine across levels. One example is a no-execute bit on an intermediate entry that only matters once the final entry is reached. Another is a reserved bit that becomes reserved only because the size bit is set in that same entry. The bench builds sparse table chains in its memory model, sharing the upper levels between cases. It places the offending bit at one chosen level, then repeats the same address with a harmless access kind to show that the fault comes from that combination. The memory latency rotates between one and three cycles, and results are held back for several cycles to test that they stay stable.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int IDX_W   = 9;
    localparam int OFF_W   = 12;
    localparam int FRAME_W = 40;
    localparam int MAXPA   = 52;
    localparam int ERR_W   = 16;

    localparam int BIT_P   = 0;
    localparam int BIT_W   = 1;
    localparam int BIT_U   = 2;
    localparam int BIT_PS  = 7;
    localparam int BIT_NX  = 63;

    // walk level: 3 = top table, 0 = last table
    localparam logic [1:0] LV_TOP = 2'd3;
    localparam logic [1:0] LV_1G  = 2'd2;
    localparam logic [1:0] LV_2M  = 2'd1;
    localparam logic [1:0] LV_4K  = 2'd0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_FETCH, ST_WAIT, ST_EVAL, ST_DONE, ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_1G = 2'd2
    } page_size_e;

    typedef struct packed {
        logic fetch;
        logic user;
        logic write;
    } access_t;

    typedef struct packed {
        logic nx;
        logic usr_ok;
        logic wr_ok;
    } perm_t;

    function automatic logic [IDX_W-1:0] va_index(input logic [63:0] va, input logic [1:0] lvl);
        logic [63:0] sh;
        sh = va >> (OFF_W + IDX_W * int'(lvl));
        return sh[IDX_W-1:0];
    endfunction

    function automatic logic va_canonical(input logic [63:0] va);
        return (&va[63:47]) || !(|va[63:47]);
    endfunction

    function automatic logic [ERR_W-1:0] fault_code(input logic present, input logic rsvd,
                                                     input access_t acc);
        logic [ERR_W-1:0] c;
        c    = '0;
        c[0] = present;
        c[1] = acc.write;
        c[2] = acc.user;
        c[3] = rsvd;
        c[4] = acc.fetch;
        return c;
    endfunction

endpackage

// File: rtl/pgwalk_entry_eval.sv
module pgwalk_entry_eval
    import pgwalk_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [63:0] entry,
    input  logic [1:0]  lvl,
    input  access_t     acc,
    input  perm_t       perm_in,
    output logic        absent,
    output logic        rsvd_hit,
    output logic        leaf,
    output page_size_e  leaf_size,
    output perm_t       perm_out,
    output logic        perm_fail
);

    logic hi_rsvd;
    logic big_rsvd;
    logic unused_entry;

    generate
        if (PA_W < MAXPA) begin : g_hi
            assign hi_rsvd = |entry[MAXPA-1:PA_W];
        end else begin : g_nohi
            assign hi_rsvd = 1'b0;
        end
    endgenerate

    assign unused_entry = ^{entry[62:52], entry[51:30], entry[12:8], entry[6:3]};

    always_comb begin
        absent    = ~entry[BIT_P];
        leaf      = (lvl == LV_4K) || (((lvl == LV_1G) || (lvl == LV_2M)) && entry[BIT_PS]);
        leaf_size = SZ_4K;
        big_rsvd  = 1'b0;
        if (leaf && lvl == LV_1G) begin
            leaf_size = SZ_1G;
            big_rsvd  = |entry[29:13];
        end else if (leaf && lvl == LV_2M) begin
            leaf_size = SZ_2M;
            big_rsvd  = |entry[20:13];
        end
        rsvd_hit = hi_rsvd | big_rsvd;

        perm_out.wr_ok  = perm_in.wr_ok  & entry[BIT_W];
        perm_out.usr_ok = perm_in.usr_ok & entry[BIT_U];
        perm_out.nx     = perm_in.nx     | entry[BIT_NX];
        perm_fail = (acc.write & ~perm_out.wr_ok)
                  | (acc.user  & ~perm_out.usr_ok)
                  | (acc.fetch &  perm_out.nx);
    end

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
    import pgwalk_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [63:0]        va,
    input  logic [1:0]         lvl,
    input  logic [FRAME_W-1:0] leaf_frame,
    input  page_size_e         size,
    output logic [PA_W-1:0]    rd_addr,
    output logic [63:0]        leaf_pa
);

    assign rd_addr = PA_W'({tbl_frame, va_index(va, lvl), 3'b000});

    always_comb begin
        case (size)
            SZ_2M:   leaf_pa = {12'b0, leaf_frame[39:9],  va[20:0]};
            SZ_1G:   leaf_pa = {12'b0, leaf_frame[39:18], va[29:0]};
            default: leaf_pa = {12'b0, leaf_frame,        va[11:0]};
        endcase
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               paging_en,
    input  logic [39:0]        root_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [63:0]        req_va,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               req_fetch,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [63:0]        rsp_pa,
    output logic [1:0]         rsp_size,
    output logic [15:0]        rsp_err
);

    walk_state_e          state;
    logic [1:0]           lvl;
    logic [63:0]          va_q;
    access_t              acc_q;
    perm_t                perm_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [63:0]          entry_q;
    logic [63:0]          res_pa;
    page_size_e           res_size;
    logic [ERR_W-1:0]     res_err;

    logic                 ev_absent;
    logic                 ev_rsvd;
    logic                 ev_leaf;
    page_size_e           ev_size;
    perm_t                ev_perm;
    logic                 ev_perm_fail;
    logic [PA_W-1:0]      rd_addr;
    logic [63:0]          leaf_pa;

    pgwalk_entry_eval #(.PA_W(PA_W)) u_eval (
        .entry     (entry_q),
        .lvl       (lvl),
        .acc       (acc_q),
        .perm_in   (perm_q),
        .absent    (ev_absent),
        .rsvd_hit  (ev_rsvd),
        .leaf      (ev_leaf),
        .leaf_size (ev_size),
        .perm_out  (ev_perm),
        .perm_fail (ev_perm_fail)
    );

    pgwalk_addr_gen #(.PA_W(PA_W)) u_addr (
        .tbl_frame  (frame_q),
        .va         (va_q),
        .lvl        (lvl),
        .leaf_frame (entry_q[51:12]),
        .size       (ev_size),
        .rd_addr    (rd_addr),
        .leaf_pa    (leaf_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lvl      <= LV_TOP;
            va_q     <= '0;
            acc_q    <= '0;
            perm_q   <= '0;
            frame_q  <= '0;
            entry_q  <= '0;
            res_pa   <= '0;
            res_size <= SZ_4K;
            res_err  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        acc_q   <= '{fetch: req_fetch, user: req_user, write: req_write};
                        perm_q  <= '{nx: 1'b0, usr_ok: 1'b1, wr_ok: 1'b1};
                        frame_q <= root_frame;
                        lvl     <= LV_TOP;
                        if (!paging_en) begin
                            res_pa   <= req_va;
                            res_size <= SZ_4K;
                            res_err  <= '0;
                            state    <= ST_DONE;
                        end else begin
                            state <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (!va_canonical(va_q)) begin
                        res_pa   <= '0;
                        res_size <= SZ_4K;
                        res_err  <= fault_code(1'b0, 1'b0, acc_q);
                        state    <= ST_FAULT;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        entry_q <= mem_rsp_data;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (ev_absent) begin
                        res_pa  <= '0;
                        res_err <= fault_code(1'b0, 1'b0, acc_q);
                        state   <= ST_FAULT;
                    end else if (ev_rsvd) begin
                        res_pa  <= '0;
                        res_err <= fault_code(1'b1, 1'b1, acc_q);
                        state   <= ST_FAULT;
                    end else if (ev_leaf) begin
                        if (ev_perm_fail) begin
                            res_pa  <= '0;
                            res_err <= fault_code(1'b1, 1'b0, acc_q);
                            state   <= ST_FAULT;
                        end else begin
                            res_pa   <= leaf_pa;
                            res_size <= ev_size;
                            res_err  <= '0;
                            state    <= ST_DONE;
                        end
                    end else begin
                        perm_q  <= ev_perm;
                        frame_q <= entry_q[51:12];
                        lvl     <= lvl - 2'd1;
                        state   <= ST_FETCH;
                    end
                end
                ST_DONE, ST_FAULT: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_FETCH);
    assign mem_req_addr  = rd_addr;
    assign rsp_valid     = (state == ST_DONE) || (state == ST_FAULT);
    assign rsp_fault     = (state == ST_FAULT);
    assign rsp_pa        = res_pa;
    assign rsp_size      = res_size;
    assign rsp_err       = res_err;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
    import pgwalk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        paging_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_va,
    input logic        mem_req_valid,
    input logic        mem_rsp_valid,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic        rsp_fault,
    input logic [63:0] rsp_pa,
    input logic [1:0]  rsp_size,
    input logic [15:0] rsp_err
);

    logic rd_pending;
    logic req_noncanon;

    always_ff @(posedge clk) begin
        if (rst) rd_pending <= 1'b0;
        else if (mem_req_valid) rd_pending <= 1'b1;
        else if (mem_rsp_valid) rd_pending <= 1'b0;
    end

    assign req_noncanon = (req_va[63:47] != '0) && (req_va[63:47] != '1);

    // R11
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && rd_pending));

    // R12
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));

    // R12
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                       && $stable(rsp_err) && $stable(rsp_size)));

    // R9
    err_form_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err[15:5] == '0) && (rsp_fault || rsp_err == '0));

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !paging_en) |=> (rsp_valid && !rsp_fault && rsp_pa == $past(req_va)));

    // R2
    noncanon_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && paging_en && req_noncanon)
            |=> !mem_req_valid ##1 (rsp_valid && rsp_fault && !rsp_err[0]));

    // R3
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_size != 2'd3));

endmodule

bind pgwalk_top pgwalk_chk i_chk (.*);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;

    localparam int PA_W = 46;
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;
    localparam logic [63:0] HI_MASK = ((64'd1 << 52) - 64'd1) & ~PA_MASK;
    localparam logic [63:0] NX = 64'd1 << 63;
    localparam logic [63:0] PS = 64'h80;
    localparam logic [63:0] ROOT = 64'h1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic paging_en = 1'b1;
    logic [39:0] root_frame = 40'(ROOT >> 12);
    logic req_valid = 1'b0;
    logic req_ready;
    logic [63:0] req_va = '0;
    logic req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic mem_req_valid;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic rsp_fault;
    logic [63:0] rsp_pa;
    logic [1:0] rsp_size;
    logic [15:0] rsp_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int rd_cnt = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];

    always #2 clk = ~clk;

    pgwalk_top #(.PA_W(PA_W)) i_pgwalk_top (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mkva(input int i4, input int i3, input int i2,
                                         input int i1, input int off);
        logic [47:0] v;
        v = {i4[8:0], i3[8:0], i2[8:0], i1[8:0], off[11:0]};
        return {{16{v[47]}}, v};
    endfunction

    function automatic logic [63:0] slot(input logic [63:0] tbl, input int lv, input logic [63:0] va);
        logic [63:0] idx;
        idx = (va >> (12 + 9 * (lv - 1))) & 64'd511;
        return (tbl + idx * 8) & PA_MASK;
    endfunction

    task automatic put(input logic [63:0] tbl, input int lv, input logic [63:0] va, input logic [63:0] val);
        mem[slot(tbl, lv, va)] = val;
    endtask

    // behavioural model of a translation, straight from the requirements
    task automatic ref_walk(input logic [63:0] va, input bit w, input bit u, input bit f, input bit pg,
                            output bit flt, output logic [63:0] pa, output logic [1:0] sz,
                            output logic [15:0] err);
        logic [63:0] base, e, a;
        logic [15:0] acc;
        bit wok, uok, nxs, leaf, rsv;
        acc = (w ? 16'h2 : 16'h0) | (u ? 16'h4 : 16'h0) | (f ? 16'h10 : 16'h0);
        flt = 0; pa = '0; sz = 2'd0; err = '0;
        if (!pg) begin
            pa = va;
            return;
        end
        if (!((va[63:47] == '0) || (va[63:47] == '1))) begin
            flt = 1; err = acc;
            return;
        end
        base = ROOT; wok = 1; uok = 1; nxs = 0;
        for (int lv = 4; lv >= 1; lv--) begin
            a = slot(base, lv, va);
            exp_q.push_back(a);
            e = mem.exists(a) ? mem[a] : 64'd0;
            if (!e[0]) begin
                flt = 1; err = acc;
                return;
            end
            leaf = (lv == 1) || ((lv == 3 || lv == 2) && e[7]);
            rsv = (e & HI_MASK) != 0;
            if (leaf && lv == 3) rsv = rsv || (e[29:13] != 0);
            if (leaf && lv == 2) rsv = rsv || (e[20:13] != 0);
            if (rsv) begin
                flt = 1; err = acc | 16'h9;
                return;
            end
            wok = wok && e[1]; uok = uok && e[2]; nxs = nxs || e[63];
            if (leaf) begin
                if ((w && !wok) || (u && !uok) || (f && nxs)) begin
                    flt = 1; err = acc | 16'h1;
                end else if (lv == 3) begin
                    sz = 2'd2; pa = (e & 64'h000F_FFFF_C000_0000) | {34'd0, va[29:0]};
                end else if (lv == 2) begin
                    sz = 2'd1; pa = (e & 64'h000F_FFFF_FFE0_0000) | {43'd0, va[20:0]};
                end else begin
                    sz = 2'd0; pa = (e & 64'h000F_FFFF_FFFF_F000) | {52'd0, va[11:0]};
                end
                return;
            end
            base = e & 64'h000F_FFFF_FFFF_F000;
        end
    endtask

    task automatic run(input string tag, input logic [63:0] va, input bit w, input bit u,
                       input bit f, input bit pg, input int hold);
        bit ef; logic [63:0] epa; logic [1:0] esz; logic [15:0] eerr;
        logic [63:0] spa; logic [15:0] serr; logic sfl; int cyc;
        ref_walk(va, w, u, f, pg, ef, epa, esz, eerr);
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = w; req_user = u; req_fetch = f; paging_en = pg;
        @(negedge clk);
        req_valid = 0;
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        if (!pg) chk(cyc == 0, "R10", "bypass latency", 64'(cyc), 64'd0);
        chk(rsp_valid == 1'b1, tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == ef, tag, "fault flag", 64'(rsp_fault), 64'(ef));
        chk(rsp_err == eerr, tag, "error code (R9)", 64'(rsp_err), 64'(eerr));
        if (!ef) begin
            chk(rsp_pa == epa, tag, "physical address", rsp_pa, epa);
            chk(rsp_size == esz, tag, "size code", 64'(rsp_size), 64'(esz));
        end
        spa = rsp_pa; serr = rsp_err; sfl = rsp_fault;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_pa == spa && rsp_err == serr && rsp_fault == sfl,
                "R12", "result held", rsp_pa, spa);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(!rsp_valid && req_ready, "R12", "release to idle", 64'(req_ready), 64'd1);
        chk(exp_q.size() == 0, "R1", "reads still expected", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    // memory responder, checks every read address and single-outstanding use
    initial begin
        logic [63:0] a;
        int lat;
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                a = 64'(mem_req_addr);
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected entry read", a, 64'd0);
                end else begin
                    logic [63:0] ea;
                    ea = exp_q.pop_front();
                    chk(a == ea, "R1", "entry read address", a, ea);
                end
                lat = 1 + (rd_cnt % 3);
                rd_cnt++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    chk(!mem_req_valid, "R11", "second read while pending", 64'(mem_req_valid), 64'd0);
                end
                mem_rsp_data = mem.exists(a) ? mem[a] : 64'd0;
                mem_rsp_valid = 1;
                @(negedge clk);
                mem_rsp_valid = 0;
            end
        end
    end

    // every-cycle handshake comparison
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) chk(!(req_ready && rsp_valid), "R12", "ready with result pending",
                          64'(req_ready), 64'd0);
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] va;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R12", "reset state", 64'(req_ready), 64'd1);

        // shared chain: top idx1 -> 0x2000, idx2 -> 0x3000, idx3 -> 0x4000
        va = mkva(1, 2, 3, 4, 12'h5A8);
        put(ROOT,    4, va, 64'h2000 | 7);
        put('h2000,  3, va, 64'h3000 | 7);
        put('h3000,  2, va, 64'h4000 | 7);
        put('h4000,  1, va, 64'h12_3456_7000 | 3);
        run("R5", va, 0, 0, 0, 1, 2);
        run("R5", va, 1, 0, 0, 1, 0);

        va = mkva(1, 2, 5, 9, 12'h123);
        put('h3000, 2, va, 64'h4_0020_0000 | PS | 7);
        run("R4", va, 0, 1, 0, 1, 3);

        va = mkva(1, 7, 100, 200, 12'h321);
        put('h2000, 3, va, 64'h80_4000_0000 | 64'h1000 | PS | 7);
        run("R3", va, 0, 0, 1, 1, 0);
        run("R7", va, 0, 0, 1, 1, 0);

        run("R2", 64'h0001_0000_0000_0000, 1, 1, 0, 1, 1);
        run("R2", 64'hFFFF_0000_0000_0000, 0, 0, 1, 1, 0);

        run("R6", mkva(1, 9, 0, 0, 0), 1, 0, 1, 1, 0);

        va = mkva(1, 2, 3, 5, 0);
        put('h4000, 1, va, 64'h5000 | 1);
        run("R8", va, 1, 0, 0, 1, 0);
        run("R8", va, 0, 0, 0, 1, 0);

        va = mkva(2, 0, 0, 0, 12'h10);
        put(ROOT,   4, va, 64'h6000 | 3);
        put('h6000, 3, va, 64'h7000 | 7);
        put('h7000, 2, va, 64'h8000 | 7);
        put('h8000, 1, va, 64'h9000 | 7);
        run("R8", va, 0, 1, 0, 1, 0);
        run("R8", va, 1, 0, 0, 1, 0);

        va = mkva(3, 1, 1, 1, 0);
        put(ROOT,   4, va, 64'hC000 | 7);
        put('hC000, 3, va, 64'hD000 | 7);
        put('hD000, 2, va, NX | 64'hE000 | 7);
        put('hE000, 1, va, 64'hF000 | 7);
        run("R8", va, 0, 0, 1, 1, 0);
        run("R8", va, 0, 1, 0, 1, 0);

        va = mkva(4, 1, 1, 1, 0);
        put(ROOT,   4, va, 64'hA000 | 7);
        put('hA000, 3, va, (64'd1 << 50) | 64'hB000 | 7);
        run("R7", va, 0, 0, 0, 1, 0);

        va = mkva(1, 2, 6, 0, 0);
        put('h3000, 2, va, 64'h60_0000 | (64'd1 << 13) | PS | 7);
        run("R7", va, 1, 0, 0, 1, 0);

        va = mkva(1, 8, 0, 0, 0);
        put('h2000, 3, va, 64'h4000_0000 | (64'd1 << 20) | PS | 7);
        run("R7", va, 0, 1, 0, 1, 0);

        va = mkva(300, 4, 4, 4, 12'h77);
        put(ROOT,    4, va, 64'h1_0000 | 7);
        put('h10000, 3, va, 64'h1_1000 | 7);
        put('h11000, 2, va, 64'h1_2000 | 7);
        put('h12000, 1, va, 64'h3F_FFFF_F000 | PS | 7);
        run("R5", va, 1, 1, 0, 1, 2);
        run("R1", va, 0, 0, 1, 1, 0);

        run("R10", 64'hDEAD_BEEF_0000_1234, 1, 1, 1, 0, 2);
        run("R10", mkva(1, 2, 3, 4, 0), 0, 0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule